// File: doc/BRIEF.md
# Two-Way Instruction Cache

A read-only instruction store sitting between the fetch stage and the memory refill logic. A fetch presents an effective address and, in the same cycle, the physical page number that an external translation unit produces for it. The set is picked from untranslated address bits, so the tag and data arrays are read while translation runs in parallel. One cycle later the cache reports whether the fetch hit and returns the selected 32-bit instruction word.

Each of the 256 sets holds two ways. Each way carries a 20-bit physical tag, one valid bit and a 128-bit line of four words. When a fetch misses, an outside refill controller writes a complete line through the fill port. An invalid way is taken first. Otherwise a one-bit-per-set least-recently-used flag picks the victim. A single invalidate-all input wipes every line. Nothing outside the fill port ever changes a stored line.

Top module: `icache2w`

## Requirements
- R1: After synchronous reset every line is invalid and `rsp_valid` is 0; the first fetch after reset reports a miss.
- R2: A fetch accepted with `fetch_valid`=1 yields `rsp_valid`=1 on the next clock edge and at no other time; a cycle without a fetch yields `rsp_valid`=0 after the next edge.
- R3: The set index is `fetch_ea[11:4]`, the word within the line is `fetch_ea[3:2]`, and `fetch_ea[1:0]` has no effect on the result.
- R4: A hit requires the stored tag to equal `fetch_ppn` of the same cycle; `fetch_ea[31:12]` plays no part in the comparison.
- R5: One fill cycle writes the whole line, the tag `fill_ppn` and valid=1 into set `fill_set`; word k of the line is `fill_line[32*k+31:32*k]`, and a later fetch of that line hits and returns that word.
- R6: A fill takes an invalid way before a valid one, way 0 before way 1, so two different lines filled into an empty set are both kept.
- R7: With both ways valid, the victim is the way not touched most recently, where a hit in a way or a fill into a way marks that way as most recent.
- R8: `inval_all` clears every valid bit and resets every LRU flag to way 0; a fetch in the same cycle or any later cycle misses until the line is filled again.
- R9: A hit is reported only with `rsp_valid`=1, only for a way whose valid bit is set, and never for both ways at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval_all | input | 1 | Invalidate every line and reset LRU state |
| fetch_valid | input | 1 | Fetch request strobe |
| fetch_ea | input | 32 | Effective fetch address |
| fetch_ppn | input | 20 | Translated physical page number for this fetch |
| fill_valid | input | 1 | Write a line into the cache |
| fill_set | input | 8 | Set receiving the fill |
| fill_ppn | input | 20 | Physical tag for the filled line |
| fill_line | input | 128 | Line data, word 0 in the low bits |
| rsp_valid | output | 1 | Result of the previous cycle's fetch is present |
| rsp_hit | output | 1 | That fetch hit |
| rsp_word | output | 32 | Selected instruction word (meaningful on hit) |

## Verification
The checks assume that a fill only ever follows a miss for the same line, so one set never holds the same tag twice. They also assume that a fill does not target the set being fetched in the same cycle, or the set whose hit is updating LRU in that cycle. The directed tasks hold to this: each fetch is followed by an idle cycle before any fill, and every fill in a set uses a tag not already resident there. The invalidate scenario also places `inval_all` in the same cycle as a fetch, which exercises the case where clearing races a read.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int unsigned NUM_WAYS  = 2;
  localparam int unsigned BYTE_BITS = 2;
  typedef logic [NUM_WAYS-1:0] way_vec_t;
endpackage

// File: rtl/icache_way.sv
module icache_way #(
  parameter int unsigned SETS   = 256,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned LINE_W = 128,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  output logic              rd_vld,
  output logic              wr_slot_vld
);
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];
  logic [SETS-1:0]   vld_q;

  // plain RAM: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      line_mem[wr_idx] <= wr_line;
    end
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_idx];
      rd_line <= line_mem[rd_idx];
    end
  end

  // valid bits live in flops so that a flash clear is possible
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld_q  <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_idx] <= 1'b1;
      if (rd_en) rd_vld <= vld_q[rd_idx];
    end
  end

  assign wr_slot_vld = vld_q[wr_idx];
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
  parameter int unsigned SETS = 256,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_way,
  output logic             fill_lru
);
  logic [SETS-1:0] lru_q;

  // flag names the way to replace next; a fill to the same set overrides a hit
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lru_q <= '0;
    end else begin
      if (hit_en)  lru_q[hit_idx]  <= ~hit_way;
      if (fill_en) lru_q[fill_idx] <= ~fill_way;
    end
  end

  assign fill_lru = lru_q[fill_idx];
endmodule

// File: rtl/icache2w.sv
module icache2w
  import icache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned TAG_W      = 20,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned SETS       = 256
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inval_all,
  input  logic                         fetch_valid,
  input  logic [ADDR_W-1:0]            fetch_ea,
  input  logic [TAG_W-1:0]             fetch_ppn,
  input  logic                         fill_valid,
  input  logic [$clog2(SETS)-1:0]      fill_set,
  input  logic [TAG_W-1:0]             fill_ppn,
  input  logic [WORD_W*LINE_WORDS-1:0] fill_line,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [WORD_W-1:0]            rsp_word
);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned WSEL_W = $clog2(LINE_WORDS);
  localparam int unsigned IDX_LO = BYTE_BITS + WSEL_W;
  localparam int unsigned LINE_W = WORD_W * LINE_WORDS;

  logic [IDX_W-1:0]  rd_idx;
  logic [WSEL_W-1:0] wsel_q;
  logic [TAG_W-1:0]  ppn_q;
  logic [IDX_W-1:0]  idx_q;
  logic              vld_q;

  way_vec_t          way_vld, slot_vld, victim, way_hit;
  logic [TAG_W-1:0]  way_tag  [NUM_WAYS];
  logic [LINE_W-1:0] way_line [NUM_WAYS];
  logic [LINE_W-1:0] hit_line;
  logic              fill_lru, victim_way, fill_go;

  assign rd_idx  = fetch_ea[IDX_LO +: IDX_W];
  assign fill_go = fill_valid && !inval_all;

  // stage register: request context beside the array reads
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      wsel_q <= '0;
      ppn_q  <= '0;
      idx_q  <= '0;
    end else begin
      vld_q <= fetch_valid;
      if (fetch_valid) begin
        wsel_q <= fetch_ea[BYTE_BITS +: WSEL_W];
        ppn_q  <= fetch_ppn;
        idx_q  <= rd_idx;
      end
    end
  end

  // victim: first invalid way, else the LRU flag
  always_comb begin
    if (!slot_vld[0])      victim_way = 1'b0;
    else if (!slot_vld[1]) victim_way = 1'b1;
    else                   victim_way = fill_lru;
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign victim[w] = (victim_way == 1'(w));

    icache_way #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_way (
      .clk         (clk),
      .rst         (rst),
      .clr         (inval_all),
      .rd_en       (fetch_valid),
      .rd_idx      (rd_idx),
      .wr_en       (fill_go && victim[w]),
      .wr_idx      (fill_set),
      .wr_tag      (fill_ppn),
      .wr_line     (fill_line),
      .rd_tag      (way_tag[w]),
      .rd_line     (way_line[w]),
      .rd_vld      (way_vld[w]),
      .wr_slot_vld (slot_vld[w])
    );

    assign way_hit[w] = vld_q && way_vld[w] && (way_tag[w] == ppn_q);
  end

  assign hit_line  = way_hit[1] ? way_line[1] : way_line[0];
  assign rsp_valid = vld_q;
  assign rsp_hit   = |way_hit;
  assign rsp_word  = hit_line[wsel_q*WORD_W +: WORD_W];

  icache_lru #(.SETS(SETS)) u_lru (
    .clk      (clk),
    .rst      (rst),
    .clr      (inval_all),
    .hit_en   (rsp_hit),
    .hit_idx  (idx_q),
    .hit_way  (way_hit[1]),
    .fill_en  (fill_go),
    .fill_idx (fill_set),
    .fill_way (victim_way),
    .fill_lru (fill_lru)
  );
endmodule

// File: rtl/icache_chk.sv
module icache_chk (
  input logic       clk,
  input logic       rst,
  input logic       inval_all,
  input logic       fetch_valid,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic [1:0] way_hit
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!armed)
    rst |=> !rsp_valid);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    fetch_valid |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    !fetch_valid |=> !rsp_valid);
  assert_inval_miss_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    inval_all |=> !rsp_hit);
  assert_hit_in_rsp_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    rsp_hit |-> rsp_valid);
  assert_single_way_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    rsp_valid |-> $onehot0(way_hit));
endmodule

bind icache2w icache_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .inval_all   (inval_all),
  .fetch_valid (fetch_valid),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .way_hit     (way_hit)
);

// File: tb/sim_icache2w.sv
`timescale 1ns/1ps
module sim_icache2w;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inval_all = 1'b0;
  logic         fetch_valid = 1'b0;
  logic [31:0]  fetch_ea = '0;
  logic [19:0]  fetch_ppn = '0;
  logic         fill_valid = 1'b0;
  logic [7:0]   fill_set = '0;
  logic [19:0]  fill_ppn = '0;
  logic [127:0] fill_line = '0;
  logic         rsp_valid, rsp_hit;
  logic [31:0]  rsp_word;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  icache2w u0 (
    .clk(clk), .rst(rst), .inval_all(inval_all),
    .fetch_valid(fetch_valid), .fetch_ea(fetch_ea), .fetch_ppn(fetch_ppn),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_ppn(fill_ppn), .fill_line(fill_line),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_word(rsp_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_line(input logic [31:0] seed);
    return {seed + 32'd3, seed + 32'd2, seed + 32'd1, seed};
  endfunction

  function automatic logic [31:0] mk_ea(input logic [19:0] hi, input logic [7:0] set,
                                        input logic [1:0] w, input logic [1:0] b);
    return {hi, set, w, b};
  endfunction

  task automatic do_fill(input logic [7:0] set, input logic [19:0] ppn, input logic [31:0] seed);
    @(negedge clk);
    fill_valid = 1'b1; fill_set = set; fill_ppn = ppn; fill_line = mk_line(seed);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // fetch, check the response one edge later, then one idle cycle
  task automatic expect_fetch(input string req, input logic [31:0] ea, input logic [19:0] ppn,
                              input logic exp_hit, input logic [31:0] exp_word);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_ea = ea; fetch_ppn = ppn;
    @(negedge clk);
    fetch_valid = 1'b0;
    check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hit"}, 32'(rsp_hit), 32'(exp_hit));
    if (exp_hit) check({req, " word"}, rsp_word, exp_word);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    expect_fetch("R1 first fetch misses", mk_ea(20'h0, 8'd0, 2'd0, 2'd0), 20'h0, 1'b0, 32'h0);
    check("R2 idle cycle no rsp", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_fill_hit();
    do_fill(8'd5, 20'h12345, 32'h0000_0100);
    for (int k = 0; k < 4; k++)
      expect_fetch("R5 word of filled line", mk_ea(20'h12345, 8'd5, 2'(k), 2'd0),
                   20'h12345, 1'b1, 32'h100 + 32'(k));
    expect_fetch("R3 low bits ignored", mk_ea(20'h12345, 8'd5, 2'd2, 2'd3),
                 20'h12345, 1'b1, 32'h102);
    expect_fetch("R4 ea high bits ignored", mk_ea(20'hABCDE, 8'd5, 2'd1, 2'd0),
                 20'h12345, 1'b1, 32'h101);
    expect_fetch("R4 other ppn misses", mk_ea(20'h12345, 8'd5, 2'd1, 2'd0),
                 20'h12346, 1'b0, 32'h0);
    expect_fetch("R3 other set misses", mk_ea(20'h12345, 8'd6, 2'd1, 2'd0),
                 20'h12345, 1'b0, 32'h0);
  endtask

  task automatic t_replace();
    do_fill(8'd9, 20'h0000A, 32'hA000);
    do_fill(8'd9, 20'h0000B, 32'hB000);
    expect_fetch("R6 first line kept", mk_ea(20'h0, 8'd9, 2'd0, 2'd0), 20'h0000A, 1'b1, 32'hA000);
    expect_fetch("R6 second line kept", mk_ea(20'h0, 8'd9, 2'd3, 2'd0), 20'h0000B, 1'b1, 32'hB003);
    // touch A so that B is least recent
    expect_fetch("R7 touch A", mk_ea(20'h0, 8'd9, 2'd1, 2'd0), 20'h0000A, 1'b1, 32'hA001);
    do_fill(8'd9, 20'h0000C, 32'hC000);
    expect_fetch("R7 A survives", mk_ea(20'h0, 8'd9, 2'd0, 2'd0), 20'h0000A, 1'b1, 32'hA000);
    expect_fetch("R7 B evicted", mk_ea(20'h0, 8'd9, 2'd0, 2'd0), 20'h0000B, 1'b0, 32'h0);
    expect_fetch("R7 C present", mk_ea(20'h0, 8'd9, 2'd2, 2'd0), 20'h0000C, 1'b1, 32'hC002);
    // C touched last, so A is the victim
    do_fill(8'd9, 20'h0000D, 32'hD000);
    expect_fetch("R7 D present", mk_ea(20'h0, 8'd9, 2'd1, 2'd0), 20'h0000D, 1'b1, 32'hD001);
    expect_fetch("R7 C survives", mk_ea(20'h0, 8'd9, 2'd0, 2'd0), 20'h0000C, 1'b1, 32'hC000);
    expect_fetch("R7 A evicted", mk_ea(20'h0, 8'd9, 2'd0, 2'd0), 20'h0000A, 1'b0, 32'h0);
  endtask

  task automatic t_inval();
    do_fill(8'd20, 20'h55555, 32'h5000);
    expect_fetch("R8 before clear", mk_ea(20'h0, 8'd20, 2'd0, 2'd0), 20'h55555, 1'b1, 32'h5000);
    // invalidate in the same cycle as a fetch
    @(negedge clk);
    inval_all = 1'b1; fetch_valid = 1'b1;
    fetch_ea = mk_ea(20'h0, 8'd20, 2'd0, 2'd0); fetch_ppn = 20'h55555;
    @(negedge clk);
    inval_all = 1'b0; fetch_valid = 1'b0;
    check("R8 same-cycle fetch rsp_valid", 32'(rsp_valid), 32'd1);
    check("R8 same-cycle fetch misses", 32'(rsp_hit), 32'd0);
    @(negedge clk);
    expect_fetch("R8 later fetch misses", mk_ea(20'h0, 8'd20, 2'd0, 2'd0), 20'h55555, 1'b0, 32'h0);
    expect_fetch("R8 other set cleared", mk_ea(20'h0, 8'd5, 2'd0, 2'd0), 20'h12345, 1'b0, 32'h0);
    do_fill(8'd20, 20'h66666, 32'h6000);
    do_fill(8'd20, 20'h77777, 32'h7000);
    expect_fetch("R9 refill way A", mk_ea(20'h0, 8'd20, 2'd1, 2'd0), 20'h66666, 1'b1, 32'h6001);
    expect_fetch("R9 refill way B", mk_ea(20'h0, 8'd20, 2'd1, 2'd0), 20'h77777, 1'b1, 32'h7001);
    expect_fetch("R9 stale tag misses", mk_ea(20'h0, 8'd20, 2'd1, 2'd0), 20'h55555, 1'b0, 32'h0);
  endtask

  initial begin
    t_reset();
    t_fill_hit();
    t_replace();
    t_inval();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule